// File: doc/BRIEF.md
# AGC Gain-Change Flag and Deferred Apply Controller

This block sits behind the decision logic of an automatic gain control loop. It turns gain-up and gain-down requests into two status flags, one for increments and one for decrements, each lasting exactly one output sample period. It also produces the strobe that commits a gain step to the gain stages, together with the direction of that step.

Two behaviours are selected by a 2-bit mode. In pass-through mode a request commits at once and its flag follows at once. In keep mode a request is only recorded as pending. Its flag is raised when the combined hold signal goes high, and the gain step is committed when that hold signal next goes low. The hold signal is the OR of an asynchronous hold pin, brought in through a two-stage synchronizer, and a hold register bit that is already synchronous to the clock.

The controller is a five-state machine. In `ST_PASS` the block is in pass-through mode. In `ST_OPEN` keep mode is active with hold low and nothing pending. In `ST_PEND` a direction is pending and hold is low. In `ST_KEEP` hold is high and the pending step has already been flagged. In `ST_HELD` hold is high and nothing was pending. The transitions are:
- any state goes to `ST_PASS` whenever the mode is not 01;
- `ST_PASS` or `ST_OPEN` goes to `ST_HELD` when hold is high, and to `ST_PEND` on a request;
- `ST_PASS` goes to `ST_OPEN` when neither happens;
- `ST_PEND` goes to `ST_KEEP` when hold is high, raising the flag;
- `ST_KEEP` goes to `ST_OPEN` when hold is low, committing the step;
- `ST_HELD` goes to `ST_OPEN` when hold is low.

Top module: `agc_flag_hold`

## Requirements
- R1: A request counts as "up" only when `gain_up_req` is 1 and `gain_dn_req` is 0, and as "down" only in the opposite case. With both lines high, or both low, nothing is recorded, committed or flagged in that cycle.
- R2: A flag event raises its flag at the first clock edge where `sample_stb` is 1, at or after the edge where the event is taken. The flag then stays high until the next edge with `sample_stb` high, and changes at no other edge.
- R3: In mode 00, a request sampled at edge t gives `apply_stb` = 1 for exactly the cycle after edge t. In that cycle `apply_up` is 1 for up and 0 for down. `apply_up` is defined only while `apply_stb` is 1. The matching flag event is taken at edge t.
- R4: In mode 01, a request is held as pending and does not commit. A flag event for the pending direction is taken at the edge where the combined hold is first seen high.
- R5: In mode 01, a flagged pending step commits with a one-cycle `apply_stb` at the edge where the combined hold is first seen low again, with `apply_up` giving the pending direction.
- R6: In mode 01, when several requests arrive before hold rises, only the direction of the last one stays pending.
- R7: In mode 01, a hold high phase that starts with nothing pending raises no flag, and commits nothing when it ends.
- R8: In mode 01, requests seen while the combined hold is high are discarded. This includes a request in the same cycle in which hold is first seen high.
- R9: The combined hold is `hold_bit` OR the hold pin after two clock stages. A change on `hold_pin` therefore takes effect two edges later than the same change on `hold_bit`.
- R10: Modes 10 and 11 behave exactly as mode 00.
- R11: Leaving mode 01 drops any pending step, without a commit and without a flag. Entering mode 01 while hold is already high behaves as a hold phase with nothing pending.
- R12: Out of reset, `flag_inc`, `flag_dec` and `apply_stb` are 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_stb | input | 1 | One-cycle strobe marking each output sample period |
| gain_up_req | input | 1 | Gain increase request from the AGC decision logic |
| gain_dn_req | input | 1 | Gain decrease request from the AGC decision logic |
| agc_mode | input | 2 | 01 = keep mode; any other value = pass-through |
| hold_pin | input | 1 | Asynchronous hold input, synchronized internally |
| hold_bit | input | 1 | Hold request from a clock-synchronous control register |
| flag_inc | output | 1 | Gain increment status flag, one sample period long |
| flag_dec | output | 1 | Gain decrement status flag, one sample period long |
| apply_stb | output | 1 | One-cycle strobe that commits a gain step |
| apply_up | output | 1 | Direction of the committed step, 1 = up (valid with `apply_stb`) |

## Verification
The assertions assume that `agc_mode`, `hold_bit` and both request lines are synchronous to `clk`. They also assume `sample_stb` is a level sampled at each edge, with no pulse-width rule beyond one cycle. Only `hold_pin` may change freely with respect to the clock. The stimulus drives every input on the falling edge, so each value is stable across a whole rising edge. The random phase toggles the mode, both hold sources, the requests and the strobe with independent probabilities, which reaches mode changes in the middle of a pending step and holds that overlap between pin and bit.

// File: rtl/agc_hold_pkg.sv
package agc_hold_pkg;

    typedef enum logic [2:0] {
        ST_PASS,
        ST_OPEN,
        ST_PEND,
        ST_KEEP,
        ST_HELD
    } hold_st_t;

    localparam logic [1:0] MODE_KEEP = 2'b01;

    localparam int DIR_UP = 1;
    localparam int DIR_DN = 0;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/flag_stretch.sv
module flag_stretch (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic ev,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            flag  <= 1'b0;
        end else if (stb) begin
            flag  <= armed | ev;
            armed <= 1'b0;
        end else begin
            armed <= armed | ev;
        end
    end

    // R2: the flag only moves at sample boundaries
    assert_flag_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stb) |-> $stable(flag));
endmodule

// File: rtl/agc_hold_fsm.sv
module agc_hold_fsm
    import agc_hold_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       hold,
    input  logic       up,
    input  logic       dn,
    output logic [1:0] ev,
    output logic       apply_stb,
    output logic       apply_up
);
    hold_st_t state, state_n;
    logic     pend_up, pend_up_n;
    logic     app_n, app_up_n;
    logic     req_up, req_dn, req_any, keep_mode;

    assign req_up    = up & ~dn;
    assign req_dn    = dn & ~up;
    assign req_any   = req_up | req_dn;
    assign keep_mode = (mode == MODE_KEEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_PASS;
            pend_up   <= 1'b0;
            apply_stb <= 1'b0;
            apply_up  <= 1'b0;
        end else begin
            state     <= state_n;
            pend_up   <= pend_up_n;
            apply_stb <= app_n;
            apply_up  <= app_up_n;
        end
    end

    always_comb begin
        state_n   = state;
        pend_up_n = pend_up;
        app_n     = 1'b0;
        app_up_n  = apply_up;
        if (!keep_mode) begin
            state_n = ST_PASS;
            if (req_any) begin
                app_n    = 1'b1;
                app_up_n = req_up;
            end
        end else begin
            unique case (state)
                ST_PASS, ST_OPEN: begin
                    if (hold) begin
                        state_n = ST_HELD;
                    end else if (req_any) begin
                        state_n   = ST_PEND;
                        pend_up_n = req_up;
                    end else begin
                        state_n = ST_OPEN;
                    end
                end
                ST_PEND: begin
                    if (hold)         state_n   = ST_KEEP;
                    else if (req_any) pend_up_n = req_up;
                end
                ST_KEEP: begin
                    if (!hold) begin
                        state_n  = ST_OPEN;
                        app_n    = 1'b1;
                        app_up_n = pend_up;
                    end
                end
                ST_HELD: begin
                    if (!hold) state_n = ST_OPEN;
                end
                default: state_n = ST_PASS;
            endcase
        end
    end

    always_comb begin
        ev = 2'b00;
        if (!keep_mode) begin
            ev[DIR_UP] = req_up;
            ev[DIR_DN] = req_dn;
        end else if (state == ST_PEND && hold) begin
            ev[DIR_UP] = pend_up;
            ev[DIR_DN] = ~pend_up;
        end
    end

    // R10: any mode other than keep returns the machine to pass-through
    assert_pass_outside_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_mode |=> (state == ST_PASS));

    // R4: a pending step is flagged and kept once hold is high
    assert_pend_to_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_mode && state == ST_PEND && hold) |=> (state == ST_KEEP));

    // R8: nothing commits while hold is high in keep mode
    assert_no_apply_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_mode && hold) |=> !apply_stb);

    // R5: every commit comes from a direct request or from a kept step
    assert_apply_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        apply_stb |-> ($past(!keep_mode && (up ^ dn)) || ($past(state) == ST_KEEP)));
endmodule

// File: rtl/agc_flag_hold.sv
module agc_flag_hold
    import agc_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_stb,
    input  logic       gain_up_req,
    input  logic       gain_dn_req,
    input  logic [1:0] agc_mode,
    input  logic       hold_pin,
    input  logic       hold_bit,
    output logic       flag_inc,
    output logic       flag_dec,
    output logic       apply_stb,
    output logic       apply_up
);
    localparam int NUM_DIR = 2;

    logic               pin_sync;
    logic               hold_any;
    logic [NUM_DIR-1:0] ev;
    logic [NUM_DIR-1:0] flags;

    hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hold_pin),
        .q     (pin_sync)
    );

    assign hold_any = pin_sync | hold_bit;

    agc_hold_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (agc_mode),
        .hold      (hold_any),
        .up        (gain_up_req),
        .dn        (gain_dn_req),
        .ev        (ev),
        .apply_stb (apply_stb),
        .apply_up  (apply_up)
    );

    generate
        for (genvar g = 0; g < NUM_DIR; g++) begin : g_flag
            flag_stretch u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .stb   (sample_stb),
                .ev    (ev[g]),
                .flag  (flags[g])
            );
        end
    endgenerate

    assign flag_inc = flags[DIR_UP];
    assign flag_dec = flags[DIR_DN];
endmodule

// File: tb/sim_agc_flag_hold.sv
module sim_agc_flag_hold;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_stb = 1'b0;
    logic       gain_up_req = 1'b0;
    logic       gain_dn_req = 1'b0;
    logic [1:0] agc_mode = 2'b00;
    logic       hold_pin = 1'b0;
    logic       hold_bit = 1'b0;
    logic       flag_inc, flag_dec, apply_stb, apply_up;

    always #4 clk = ~clk;   // 125 MHz

    agc_flag_hold u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .gain_up_req(gain_up_req), .gain_dn_req(gain_dn_req),
        .agc_mode(agc_mode), .hold_pin(hold_pin), .hold_bit(hold_bit),
        .flag_inc(flag_inc), .flag_dec(flag_dec),
        .apply_stb(apply_stb), .apply_up(apply_up)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R12";
    bit auto_stb = 1;
    int stb_cnt = 0;

    // reference state: 0 pass, 1 open, 2 pending, 3 kept, 4 held-empty
    int m_st = 0;
    bit m_pend = 0, m_s1 = 0, m_s2 = 0;
    bit [1:0] m_arm = 0, m_flag = 0;
    bit m_app = 0, m_appup = 0;

    function automatic bit valid_up(bit u, bit d);
        return u && !d;                        // R1
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        bit h, ru, rd, ra;
        bit [1:0] ev;
        int n_st;
        bit n_pend, n_app, n_appup;
        if (auto_stb) begin
            sample_stb = (stb_cnt == 0);
            stb_cnt = (stb_cnt + 1) % 4;
        end
        h  = m_s2 | hold_bit;                  // R9
        ru = valid_up(gain_up_req, gain_dn_req);
        rd = valid_up(gain_dn_req, gain_up_req);
        ra = ru | rd;
        ev = 2'b00; n_st = m_st; n_pend = m_pend; n_app = 0; n_appup = m_appup;
        if (agc_mode != 2'b01) begin           // R3, R10
            n_st = 0;
            if (ra) begin n_app = 1; n_appup = ru; end
            ev = {ru, rd};
        end else begin
            case (m_st)
                0, 1: if (h) n_st = 4;
                      else if (ra) begin n_st = 2; n_pend = ru; end
                      else n_st = 1;
                2: if (h) begin n_st = 3; ev = {m_pend, !m_pend}; end
                   else if (ra) n_pend = ru;
                3: if (!h) begin n_st = 1; n_app = 1; n_appup = m_pend; end
                default: if (!h) n_st = 1;
            endcase
        end
        @(posedge clk);
        if (sample_stb) begin m_flag = m_arm | ev; m_arm = 0; end
        else m_arm = m_arm | ev;
        m_s2 = m_s1; m_s1 = hold_pin;
        m_st = n_st; m_pend = n_pend; m_app = n_app; m_appup = n_appup;
        @(negedge clk);
        check(cur_req, "flag_inc", flag_inc, m_flag[1]);
        check(cur_req, "flag_dec", flag_dec, m_flag[0]);
        check(cur_req, "apply_stb", apply_stb, m_app);
        if (m_app) check(cur_req, "apply_up", apply_up, m_appup);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic req(bit u, bit d);
        gain_up_req = u; gain_dn_req = d;
        tick();
        gain_up_req = 0; gain_dn_req = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250601));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: quiet after reset (reference state is the reset state)
        check("R12", "flag_inc", flag_inc, 0);
        check("R12", "flag_dec", flag_dec, 0);
        check("R12", "apply_stb", apply_stb, 0);
        cur_req = "R12"; ticks(3);

        cur_req = "R3";  agc_mode = 2'b00; req(1, 0); ticks(5); req(0, 1); ticks(5);
        cur_req = "R2";  req(1, 0); req(1, 0); ticks(9); req(0, 1); ticks(2); req(1, 0); ticks(8);
        cur_req = "R1";  req(1, 1); ticks(6);
        cur_req = "R10"; agc_mode = 2'b10; req(1, 0); ticks(3);
                         agc_mode = 2'b11; req(0, 1); ticks(6);

        cur_req = "R4";  agc_mode = 2'b01; ticks(2); req(1, 0); ticks(6);
                         hold_bit = 1; ticks(6);
        cur_req = "R5";  hold_bit = 0; ticks(6);
        cur_req = "R6";  req(0, 1); req(1, 0); ticks(1); req(0, 1); ticks(2);
        cur_req = "R9";  hold_pin = 1; ticks(7); hold_pin = 0; ticks(7);
        cur_req = "R6";  req(1, 0); req(0, 1); req(1, 0);
                         hold_bit = 1; ticks(5); hold_bit = 0; ticks(5);
        cur_req = "R7";  hold_bit = 1; ticks(6); hold_bit = 0; ticks(6);
        cur_req = "R8";  hold_bit = 1; req(1, 0); ticks(3); req(0, 1);
                         hold_bit = 0; ticks(6);
                         gain_dn_req = 1; hold_bit = 1; tick(); gain_dn_req = 0;
                         ticks(3); hold_bit = 0; ticks(6);
        cur_req = "R11"; req(1, 0); ticks(2); agc_mode = 2'b00; ticks(6);
                         hold_bit = 1; ticks(2); agc_mode = 2'b01; ticks(5);
                         hold_bit = 0; ticks(6);
                         req(0, 1); hold_bit = 1; ticks(3); agc_mode = 2'b00; ticks(2);
                         hold_bit = 0; agc_mode = 2'b01; ticks(6);

        cur_req = "R2";  auto_stb = 0;
        for (int i = 0; i < 4000; i++) begin
            sample_stb  = ($urandom_range(0, 4) == 0);
            gain_up_req = ($urandom_range(0, 7) == 0);
            gain_dn_req = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 39) == 0) agc_mode = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b01;
            if ($urandom_range(0, 11) == 0) hold_bit = ~hold_bit;
            if ($urandom_range(0, 15) == 0) hold_pin = ~hold_pin;
            tick();
        end
        gain_up_req = 0; gain_dn_req = 0;
        finish_run();
    end
endmodule